// File: doc/BRIEF.md
# Filter conversion launch sequencer

This block decides when one filter of a multi-filter sigma-delta front end starts a conversion and which input channel that conversion uses. It serves two groups. The regular group converts one chosen channel, either once or back to back. It is started by a software pulse or by the start pulse of filter 0. The injected group converts the channels set in a mask. It is started by a selected external trigger edge, by the filter-0 start pulse, or by software. It runs either the whole mask per event (scan) or one channel per event.

Each launch is a one-cycle `start_o` pulse that carries a channel index and a group flag. The converter answers with a one-cycle `done_i` and a result word. The result is stored in the data output of its group, and that group's end-of-conversion flag is raised. Injected results also carry the channel index, so a scan can be unpacked in order. Dropping the enable aborts all activity.

Top module: `conv_launch_seq`

## Requirements
- R1: The trigger edge mode `trig_mode_i` is decoded as 0 = disabled, 1 = rising edge, 2 = falling edge, 3 = both edges. An edge of the selected line in the chosen sense starts one injected conversion when the injected group is idle.
- R2: `trig_sel_i` (5 bits) selects one of 32 trigger lines. Only lines 0 to 8 and 26 to 28 are populated. Any other select value gives no trigger, and lines that are not selected have no effect.
- R3: In scan mode (`inj_scan_i` = 1) one injected start converts every channel set in `inj_mask_i`, in ascending index order, back to back.
- R4: In non-scan mode one injected start converts only the next channel in the mask. The next channel is searched upward from the channel after the last one converted, and the search wraps from the top index to the lowest set bit.
- R5: A `reg_swstart_i` pulse converts channel `reg_ch_i` exactly once when `reg_cont_i` = 0. The launch is marked `start_inj_o` = 0.
- R6: With `reg_cont_i` = 1, regular conversions restart one cycle after each completion. After `reg_cont_i` is cleared, no further regular launch occurs.
- R7: An injected start request (trigger, software or sync) that arrives while an injected sequence or conversion is in progress is ignored.
- R8: An injected request that arrives during a regular conversion is held. It launches at the next conversion boundary, ahead of a continuous regular conversion, and regular conversion resumes afterwards.
- R9: When `reg_sync_i` or `inj_sync_i` is set, a `sync_i` pulse launches that group in the same cycle, with no register delay. When the enable is clear, `sync_i` has no effect.
- R10: A completion updates only the data output of its own group and sets that group's flag (`reg_eoc_o` or `inj_eoc_o`). The flag clears when the same group launches again. `inj_ch_o` holds the channel of the last injected result.
- R11: Clearing `en_i` aborts the conversion in progress and any remaining scan, and clears both flags. It also resets the channel pointer, so the next non-scan start converts the lowest set mask bit.
- R12: Each trigger line passes through a two-flop synchronizer. A launch appears in the second cycle after a line change, and not in the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Filter enable; low aborts and clears |
| reg_ch_i | input | 3 | Regular group channel |
| reg_cont_i | input | 1 | Regular continuous mode |
| reg_sync_i | input | 1 | Regular group starts on sync_i |
| reg_swstart_i | input | 1 | Regular software start pulse |
| inj_mask_i | input | 8 | Injected channel mask |
| inj_scan_i | input | 1 | Injected scan mode |
| inj_sync_i | input | 1 | Injected group starts on sync_i |
| inj_swstart_i | input | 1 | Injected software start pulse |
| trig_mode_i | input | 2 | Trigger edge mode |
| trig_sel_i | input | 5 | Trigger line select |
| trig_i | input | 32 | External trigger lines (asynchronous) |
| sync_i | input | 1 | Start pulse of filter 0 |
| start_o | output | 1 | Conversion launch pulse |
| start_ch_o | output | 3 | Channel of the launch |
| start_inj_o | output | 1 | Launch belongs to the injected group |
| busy_o | output | 1 | Conversion in progress |
| done_i | input | 1 | Conversion complete pulse |
| result_i | input | 24 | Conversion result |
| reg_data_o | output | 24 | Last regular result |
| reg_eoc_o | output | 1 | Regular end-of-conversion flag |
| inj_data_o | output | 24 | Last injected result |
| inj_ch_o | output | 3 | Channel of the last injected result |
| inj_eoc_o | output | 1 | Injected end-of-conversion flag |

## Verification
The bench drives every edge mode against populated lines, unpopulated lines and unselected lines. A broken edge decoder or source mux shows up there as extra or missing launches. It checks the exact channel order of a scan and the wrap of a non-scan walk, which catch a pointer that restarts at zero or skips a bit. It also issues a second start inside a running scan; a design that re-arms on it would produce more than one pass. Further cases are an injected request during a continuous regular run, where a lost request or lost priority changes the logged group order, and a sync pulse checked within its own cycle, where a registered path would lag by one. Last, the enable is dropped mid-scan; a design that keeps its pointer would pick the wrong channel after re-enable.

// File: rtl/conv_launch_pkg.sv
package conv_launch_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;
endpackage

// File: rtl/trig_front.sv
module trig_front
  import conv_launch_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 32,
  parameter int unsigned TSEL_W = $clog2(NUM_TRIG),
  parameter logic [NUM_TRIG-1:0] TRIG_VALID = 32'h1C00_01FF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic [TSEL_W-1:0]   sel_i,
  input  logic [1:0]          mode_i,
  output logic                evt_o
);
  logic [NUM_TRIG-1:0] s1_q, s2_q;
  logic sel_line, prev_q;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[g] <= 1'b0;
        s2_q[g] <= 1'b0;
      end else begin
        s1_q[g] <= trig_i[g];
        s2_q[g] <= s1_q[g];
      end
    end
  end

  assign sel_line = TRIG_VALID[sel_i] & s2_q[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sel_line;
  end

  always_comb begin
    unique case (edge_mode_e'(mode_i))
      EDGE_RISE: evt_o = sel_line & ~prev_q;
      EDGE_FALL: evt_o = ~sel_line & prev_q;
      EDGE_BOTH: evt_o = sel_line ^ prev_q;
      default:   evt_o = 1'b0;
    endcase
  end

  // R12: an event needs the synchronized line to have changed value
  a_r12_evt_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (sel_line != prev_q));
  // R2: unpopulated selects never fire
  a_r2_unpopulated_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !TRIG_VALID[sel_i] |-> !evt_o);
endmodule

// File: rtl/inj_seq.sv
module inj_seq #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic              scan_i,
  input  logic              launch_i,
  output logic [CH_W-1:0]   next_ch_o,
  output logic              any_o,
  output logic              seq_o
);
  logic [CH_W-1:0] ptr_q, base;
  logic seq_q, found, more;

  assign any_o = |mask_i;
  assign seq_o = seq_q;
  assign base  = (scan_i && !seq_q) ? '0 : ptr_q;

  // cyclic search for the first set bit at or after base
  always_comb begin
    found     = 1'b0;
    next_ch_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (!found && mask_i[(int'(base) + i) % NUM_CH]) begin
        found     = 1'b1;
        next_ch_o = CH_W'((int'(base) + i) % NUM_CH);
      end
    end
    more = 1'b0;
    for (int i = 0; i < NUM_CH; i++)
      if (mask_i[i] && i > int'(next_ch_o)) more = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      seq_q <= 1'b0;
    end else if (abort_i) begin
      ptr_q <= '0;
      seq_q <= 1'b0;
    end else if (launch_i) begin
      seq_q <= scan_i & more;
      if (next_ch_o == CH_W'(NUM_CH - 1) || (scan_i && !more)) ptr_q <= '0;
      else ptr_q <= next_ch_o + 1'b1;
    end
  end

  // R11: pointer back at zero after an abort
  a_r11_ptr_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (ptr_q == '0 && !seq_q));
  // R3: a scan remains open only after a scan launch
  a_r3_seq_from_scan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seq_q) |-> $past(scan_i && launch_i));
endmodule

// File: rtl/result_store.sv
module result_store #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CH_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              busy_i,
  input  logic              cur_inj_i,
  input  logic [CH_W-1:0]   cur_ch_i,
  input  logic              reg_launch_i,
  input  logic              inj_launch_i,
  output logic [DATA_W-1:0] reg_data_o,
  output logic              reg_eoc_o,
  output logic [DATA_W-1:0] inj_data_o,
  output logic [CH_W-1:0]   inj_ch_o,
  output logic              inj_eoc_o
);
  logic fin;
  assign fin = done_i & busy_i & ~abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_data_o <= '0;
      reg_eoc_o  <= 1'b0;
      inj_data_o <= '0;
      inj_ch_o   <= '0;
      inj_eoc_o  <= 1'b0;
    end else if (abort_i) begin
      reg_eoc_o <= 1'b0;
      inj_eoc_o <= 1'b0;
    end else begin
      if (reg_launch_i) reg_eoc_o <= 1'b0;
      if (inj_launch_i) inj_eoc_o <= 1'b0;
      if (fin && cur_inj_i) begin
        inj_data_o <= result_i;
        inj_ch_o   <= cur_ch_i;
        inj_eoc_o  <= 1'b1;
      end else if (fin) begin
        reg_data_o <= result_i;
        reg_eoc_o  <= 1'b1;
      end
    end
  end

  // R10: a flag rises only after a completion of its own group
  a_r10_reg_flag_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_eoc_o) |-> $past(done_i && !cur_inj_i));
  a_r10_inj_flag_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inj_eoc_o) |-> $past(done_i && cur_inj_i));
endmodule

// File: rtl/conv_launch_seq.sv
module conv_launch_seq #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned NUM_TRIG = 32,
  parameter int unsigned DATA_W = 24,
  parameter logic [NUM_TRIG-1:0] TRIG_VALID = 32'h1C00_01FF,
  localparam int unsigned CH_W = $clog2(NUM_CH),
  localparam int unsigned TSEL_W = $clog2(NUM_TRIG)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [CH_W-1:0]     reg_ch_i,
  input  logic                reg_cont_i,
  input  logic                reg_sync_i,
  input  logic                reg_swstart_i,
  input  logic [NUM_CH-1:0]   inj_mask_i,
  input  logic                inj_scan_i,
  input  logic                inj_sync_i,
  input  logic                inj_swstart_i,
  input  logic [1:0]          trig_mode_i,
  input  logic [TSEL_W-1:0]   trig_sel_i,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic                sync_i,
  output logic                start_o,
  output logic [CH_W-1:0]     start_ch_o,
  output logic                start_inj_o,
  output logic                busy_o,
  input  logic                done_i,
  input  logic [DATA_W-1:0]   result_i,
  output logic [DATA_W-1:0]   reg_data_o,
  output logic                reg_eoc_o,
  output logic [DATA_W-1:0]   inj_data_o,
  output logic [CH_W-1:0]     inj_ch_o,
  output logic                inj_eoc_o
);
  logic trig_evt, abort;
  logic busy_q, cur_inj_q, inj_pend_q, reg_pend_q, arm_q;
  logic [CH_W-1:0] cur_ch_q, inj_next;
  logic inj_any, inj_seq, inj_busy, inj_new, inj_accept, inj_want;
  logic reg_new, reg_want, launch_inj, launch_reg;

  assign abort = ~en_i;

  trig_front #(.NUM_TRIG(NUM_TRIG), .TSEL_W(TSEL_W), .TRIG_VALID(TRIG_VALID)) u_trig (
    .clk_i, .rst_ni, .trig_i, .sel_i(trig_sel_i), .mode_i(trig_mode_i), .evt_o(trig_evt)
  );

  inj_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_seq (
    .clk_i, .rst_ni, .abort_i(abort), .mask_i(inj_mask_i), .scan_i(inj_scan_i),
    .launch_i(launch_inj), .next_ch_o(inj_next), .any_o(inj_any), .seq_o(inj_seq)
  );

  // request arbitration; injected wins over regular at an idle boundary
  assign inj_busy   = inj_seq | (busy_q & cur_inj_q);
  assign inj_new    = inj_swstart_i | (inj_sync_i & sync_i) | trig_evt;
  assign inj_accept = en_i & inj_any & inj_new & ~inj_busy & ~inj_pend_q;
  assign inj_want   = en_i & inj_any & (inj_pend_q | inj_seq | inj_accept);
  assign reg_new    = reg_swstart_i | (reg_sync_i & sync_i);
  assign reg_want   = en_i & (reg_new | reg_pend_q | arm_q);
  assign launch_inj = ~busy_q & inj_want;
  assign launch_reg = ~busy_q & ~inj_want & reg_want;

  assign start_o     = launch_inj | launch_reg;
  assign start_inj_o = launch_inj;
  assign start_ch_o  = launch_inj ? inj_next : reg_ch_i;
  assign busy_o      = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cur_inj_q  <= 1'b0;
      cur_ch_q   <= '0;
      inj_pend_q <= 1'b0;
      reg_pend_q <= 1'b0;
      arm_q      <= 1'b0;
    end else if (abort) begin
      busy_q     <= 1'b0;
      inj_pend_q <= 1'b0;
      reg_pend_q <= 1'b0;
      arm_q      <= 1'b0;
    end else begin
      if (start_o) begin
        busy_q    <= 1'b1;
        cur_inj_q <= launch_inj;
        cur_ch_q  <= start_ch_o;
      end else if (done_i) begin
        busy_q <= 1'b0;
      end
      if (launch_inj)      inj_pend_q <= 1'b0;
      else if (inj_accept) inj_pend_q <= 1'b1;
      if (launch_reg)      reg_pend_q <= 1'b0;
      else if (reg_new)    reg_pend_q <= 1'b1;
      if (!reg_cont_i)     arm_q <= 1'b0;
      else if (launch_reg) arm_q <= 1'b1;
    end
  end

  result_store #(.DATA_W(DATA_W), .CH_W(CH_W)) u_res (
    .clk_i, .rst_ni, .abort_i(abort), .done_i, .result_i, .busy_i(busy_q),
    .cur_inj_i(cur_inj_q), .cur_ch_i(cur_ch_q), .reg_launch_i(launch_reg),
    .inj_launch_i(launch_inj), .reg_data_o, .reg_eoc_o, .inj_data_o, .inj_ch_o, .inj_eoc_o
  );

  // R3 / R4: injected launches only pick masked channels
  a_r4_ch_in_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && start_inj_o) |-> inj_mask_i[start_ch_o]);
  // R7: no new launch while a conversion runs
  a_r7_no_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_o);
  // R9: sync pulse launches in its own cycle
  a_r9_sync_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !busy_o && sync_i && (reg_sync_i || (inj_sync_i && inj_any))) |-> start_o);
  // R11: disable clears activity and flags
  a_r11_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!busy_o && !reg_eoc_o && !inj_eoc_o));
  a_r11_no_start_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !start_o);
endmodule

// File: tb/conv_launch_seq_bench.sv
module conv_launch_seq_bench;
  logic clk = 1'b0, rst_ni = 1'b0, en_i = 1'b0;
  logic [2:0] reg_ch_i = '0;
  logic reg_cont_i = 0, reg_sync_i = 0, reg_swstart_i = 0;
  logic [7:0] inj_mask_i = '0;
  logic inj_scan_i = 0, inj_sync_i = 0, inj_swstart_i = 0;
  logic [1:0] trig_mode_i = '0;
  logic [4:0] trig_sel_i = '0;
  logic [31:0] trig_i = '0;
  logic sync_i = 0, done_i = 0;
  logic [23:0] result_i = '0;
  logic start_o, start_inj_o, busy_o, reg_eoc_o, inj_eoc_o;
  logic [2:0] start_ch_o, inj_ch_o;
  logic [23:0] reg_data_o, inj_data_o;

  always #5 clk = ~clk;

  conv_launch_seq u_conv_launch_seq (
    .clk_i(clk), .rst_ni, .en_i, .reg_ch_i, .reg_cont_i, .reg_sync_i, .reg_swstart_i,
    .inj_mask_i, .inj_scan_i, .inj_sync_i, .inj_swstart_i, .trig_mode_i, .trig_sel_i,
    .trig_i, .sync_i, .start_o, .start_ch_o, .start_inj_o, .busy_o, .done_i, .result_i,
    .reg_data_o, .reg_eoc_o, .inj_data_o, .inj_ch_o, .inj_eoc_o
  );

  int checks = 0, errors = 0;
  int n_start = 0;
  int cd = 0;
  logic [2:0] mch = '0;
  logic [2:0] log_ch [256];
  logic       log_inj [256];

  // launch monitor and converter model (answers 3 cycles after launch)
  always @(posedge clk) begin
    if (rst_ni && start_o) begin
      log_ch[n_start[7:0]]  = start_ch_o;
      log_inj[n_start[7:0]] = start_inj_o;
      n_start = n_start + 1;
      cd = 3;
      mch = start_ch_o;
    end
  end
  always @(negedge clk) begin
    done_i = 1'b0;
    if (cd > 0) begin
      cd = cd - 1;
      if (cd == 0) begin
        done_i = 1'b1;
        result_i = 24'hA00000 | 24'(mch);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0] mode;
    logic [4:0] sel;
    logic [4:0] line;
    logic       exp_rise;
    logic       exp_fall;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd1, 5'd3,  5'd3,  1'b1, 1'b0},
    '{2'd2, 5'd3,  5'd3,  1'b0, 1'b1},
    '{2'd3, 5'd7,  5'd7,  1'b1, 1'b1},
    '{2'd0, 5'd7,  5'd7,  1'b0, 1'b0},
    '{2'd1, 5'd26, 5'd26, 1'b1, 1'b0},
    '{2'd1, 5'd12, 5'd12, 1'b0, 1'b0},
    '{2'd3, 5'd28, 5'd28, 1'b1, 1'b1},
    '{2'd1, 5'd5,  5'd6,  1'b0, 1'b0}
  };

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int c0, k;
    bit ok;
    step(3);
    chk(!start_o && !busy_o && !reg_eoc_o && !inj_eoc_o, "R11 reset state", int'(start_o), 0);
    rst_ni = 1'b1;
    en_i = 1'b1;
    step(2);

    // R1 R2: vector walk over edge modes and trigger selects
    inj_mask_i = 8'h04;
    for (int v = 0; v < 8; v++) begin
      trig_mode_i = VEC[v].mode;
      trig_sel_i  = VEC[v].sel;
      step(4);
      c0 = n_start;
      trig_i[VEC[v].line] = 1'b1;
      step(12);
      chk(n_start - c0 == int'(VEC[v].exp_rise), $sformatf("R1 R2 vec%0d rise", v),
          n_start - c0, int'(VEC[v].exp_rise));
      c0 = n_start;
      trig_i[VEC[v].line] = 1'b0;
      step(12);
      chk(n_start - c0 == int'(VEC[v].exp_fall), $sformatf("R1 R2 vec%0d fall", v),
          n_start - c0, int'(VEC[v].exp_fall));
    end

    // R12: synchronizer latency
    trig_mode_i = 2'd1; trig_sel_i = 5'd1;
    step(3);
    trig_i[1] = 1'b1;
    step(1);
    chk(!start_o, "R12 no launch first cycle", int'(start_o), 0);
    step(1);
    chk(start_o && start_inj_o && start_ch_o == 3'd2, "R12 launch second cycle", int'(start_o), 1);
    step(10);
    trig_i[1] = 1'b0;
    trig_mode_i = 2'd0;
    step(10);

    // R5 R10: regular single conversion
    reg_ch_i = 3'd5;
    c0 = n_start;
    reg_swstart_i = 1'b1; step(1); reg_swstart_i = 1'b0;
    step(8);
    chk(n_start - c0 == 1, "R5 single launch count", n_start - c0, 1);
    chk(log_ch[c0[7:0]] == 3'd5 && !log_inj[c0[7:0]], "R5 regular channel", int'(log_ch[c0[7:0]]), 5);
    chk(reg_eoc_o && reg_data_o == 24'hA00005, "R10 regular data", int'(reg_data_o), 'hA00005);
    chk(inj_data_o == 24'hA00002, "R10 injected data untouched", int'(inj_data_o), 'hA00002);
    reg_ch_i = 3'd3;
    reg_swstart_i = 1'b1; step(1); reg_swstart_i = 1'b0;
    chk(!reg_eoc_o && busy_o, "R10 flag clears at relaunch", int'(reg_eoc_o), 0);
    step(8);

    // R6: continuous
    c0 = n_start;
    reg_cont_i = 1'b1;
    reg_swstart_i = 1'b1; step(1); reg_swstart_i = 1'b0;
    step(40);
    chk(n_start - c0 >= 9, "R6 continuous launches", n_start - c0, 10);
    reg_cont_i = 1'b0;
    step(6);
    c0 = n_start;
    step(20);
    chk(n_start == c0, "R6 stops after clear", n_start - c0, 0);

    // R3: scan order
    inj_mask_i = 8'b1010_0110; inj_scan_i = 1'b1;
    c0 = n_start;
    inj_swstart_i = 1'b1; step(1); inj_swstart_i = 1'b0;
    step(30);
    chk(n_start - c0 == 4, "R3 scan count", n_start - c0, 4);
    ok = log_ch[c0[7:0]] == 1 && log_ch[8'(c0+1)] == 2 && log_ch[8'(c0+2)] == 5 && log_ch[8'(c0+3)] == 7;
    chk(ok, "R3 scan order", int'(log_ch[8'(c0+2)]), 5);
    chk(inj_eoc_o && inj_ch_o == 3'd7 && inj_data_o == 24'hA00007, "R10 injected channel tag",
        int'(inj_ch_o), 7);

    // R4: non-scan walk with wrap
    inj_mask_i = 8'b0100_1001; inj_scan_i = 1'b0;
    c0 = n_start;
    for (int t = 0; t < 4; t++) begin
      inj_swstart_i = 1'b1; step(1); inj_swstart_i = 1'b0;
      step(8);
    end
    ok = log_ch[c0[7:0]] == 0 && log_ch[8'(c0+1)] == 3 && log_ch[8'(c0+2)] == 6 && log_ch[8'(c0+3)] == 0;
    chk(n_start - c0 == 4 && ok, "R4 walk and wrap", int'(log_ch[8'(c0+3)]), 0);

    // R7: start during running scan is ignored
    inj_mask_i = 8'hFF; inj_scan_i = 1'b1;
    c0 = n_start;
    inj_swstart_i = 1'b1; step(1); inj_swstart_i = 1'b0;
    step(6);
    inj_swstart_i = 1'b1; step(1); inj_swstart_i = 1'b0;
    step(60);
    chk(n_start - c0 == 8, "R7 second start ignored", n_start - c0, 8);

    // R8: injected priority over continuous regular
    inj_mask_i = 8'h02; inj_scan_i = 1'b0;
    reg_ch_i = 3'd5;
    c0 = n_start;
    reg_cont_i = 1'b1;
    reg_swstart_i = 1'b1; step(1); reg_swstart_i = 1'b0;
    step(2);
    inj_swstart_i = 1'b1; step(1); inj_swstart_i = 1'b0;
    step(20);
    reg_cont_i = 1'b0;
    step(10);
    ok = !log_inj[c0[7:0]] && log_inj[8'(c0+1)] && log_ch[8'(c0+1)] == 3'd1 && !log_inj[8'(c0+2)];
    chk(ok, "R8 held injected then regular resumes", int'(log_inj[8'(c0+1)]), 1);

    // R9: sync starts
    reg_sync_i = 1'b1;
    sync_i = 1'b1; #1;
    chk(start_o && !start_inj_o && start_ch_o == 3'd5, "R9 regular sync same cycle", int'(start_o), 1);
    step(1); sync_i = 1'b0;
    step(8);
    reg_sync_i = 1'b0;
    sync_i = 1'b1; #1;
    chk(!start_o, "R9 sync without enable ignored", int'(start_o), 0);
    step(1); sync_i = 1'b0;
    step(4);
    inj_sync_i = 1'b1; inj_mask_i = 8'h10;
    sync_i = 1'b1; #1;
    chk(start_o && start_inj_o && start_ch_o == 3'd4, "R9 injected sync same cycle", int'(start_ch_o), 4);
    step(1); sync_i = 1'b0; inj_sync_i = 1'b0;
    step(8);

    // R11: abort mid-scan, then pointer reset
    inj_mask_i = 8'hFF; inj_scan_i = 1'b1;
    c0 = n_start;
    inj_swstart_i = 1'b1; step(1); inj_swstart_i = 1'b0;
    step(1);
    en_i = 1'b0; step(3); en_i = 1'b1;
    step(20);
    chk(n_start - c0 == 1, "R11 abort stops scan", n_start - c0, 1);
    inj_mask_i = 8'h0C; inj_scan_i = 1'b0;
    inj_swstart_i = 1'b1; step(1); inj_swstart_i = 1'b0;
    step(8);
    chk(inj_eoc_o, "R11 flag set before disable", int'(inj_eoc_o), 1);
    en_i = 1'b0; step(2);
    chk(!inj_eoc_o && !reg_eoc_o, "R11 flags cleared", int'(inj_eoc_o), 0);
    en_i = 1'b1;
    c0 = n_start;
    inj_swstart_i = 1'b1; step(1); inj_swstart_i = 1'b0;
    step(8);
    chk(n_start - c0 == 1 && log_ch[c0[7:0]] == 3'd2, "R11 pointer back to lowest bit",
        int'(log_ch[c0[7:0]]), 2);

    summary();
  end
endmodule